// File: doc/BRIEF.md
# Signed-Amount Barrel Shifter with Status Flags

This block is a purely combinational 32-bit shifter for a DSP datapath. It takes a data word, a 16-bit half-word that carries the shift amount, and a one-bit mode select. The direction comes from the sign of the amount. A positive count shifts left with zero fill. A negative count shifts right. In arithmetic mode a right shift fills with the sign bit, and in logical mode it fills with zeros.

Only the low 6 bits of the amount half-word are used, and they are read as a two's-complement count from -32 to +31. Larger amounts therefore do not clamp. They wrap: an amount of 40 acts as a right shift by 24, and amounts of 63 or 255 act as a right shift by 1.

Alongside the result the block drives five status values for an external status register: zero, negative, carry and two overflow indications. This non-saturating shifter drives carry and both overflow values to 0. The datapath samples the result and flags in the same cycle in which it presents the operands. Because the shifter is a pure function, it has no handshake and needs no back-pressure. The valid/ready convention of the surrounding stream belongs to the stage that registers the result.

Top module: `shf_signed_shift`

## Requirements
- R1: The shift count is `amt_hw[5:0]`, read as a 6-bit two's-complement number. `amt_hw[15:6]` has no effect on any output. For example, 40 acts as -24, 63 and 255 act as -1, and 32 acts as -32.
- R2: A count from +1 to +31 shifts `op_a` left by that count. Vacated low bits are 0 and bits shifted out are lost, so 0x80000001 by 31 gives 0x80000000.
- R3: With `mode_arith` = 1 and a count from -1 to -31, `op_a` shifts right by the magnitude and vacated high bits copy `op_a[31]`. For example, 0x80000001 by -1 gives 0xC0000000.
- R4: With `mode_arith` = 0 and a count from -1 to -31, `op_a` shifts right by the magnitude with zero fill. For example, 0x80000001 by -31 gives 0x00000001.
- R5: A count of -32 gives all 32 bits equal to `op_a[31]` when `mode_arith` = 1, and gives 0 when `mode_arith` = 0.
- R6: A count of 0 passes `op_a` to `res` unchanged in both modes.
- R7: `flg_zero` is 1 exactly when `res` is 0.
- R8: `flg_neg` equals `res[31]`.
- R9: `flg_carry`, `flg_ovf0` and `flg_ovf1` are 0 for every input, including left shifts that discard set bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Data word to shift |
| amt_hw | input | 16 | Shift amount half-word; only bits 5:0 are used |
| mode_arith | input | 1 | 1 = arithmetic right shift (sign fill), 0 = logical right shift (zero fill) |
| res | output | 32 | Shifted word |
| flg_zero | output | 1 | Result is all zeros |
| flg_neg | output | 1 | Copy of result bit 31 |
| flg_carry | output | 1 | Carry indication, always 0 |
| flg_ovf0 | output | 1 | First overflow indication, always 0 |
| flg_ovf1 | output | 1 | Second overflow indication, always 0 |

## Verification
Every result and flag is due in the same cycle as its stimulus, with zero register stages between the inputs and the outputs. The bench drives each input set just after a falling clock edge. It reads the outputs one nanosecond later, well before the next rising edge, so no check depends on the ordering of events at an edge. The sweep covers all 64 count fields in both modes over several operands. Each vector carries a varying pattern in the unused upper amount bits, and every result is compared against a value computed arithmetically from the 6-bit count alone.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic {
    SHF_LOGIC = 1'b0,
    SHF_ARITH = 1'b1
  } shf_mode_e;

  typedef struct packed {
    logic zero;
    logic neg;
    logic carry;
    logic ovf0;
    logic ovf1;
  } shf_flags_t;
endpackage

// File: rtl/shf_count_decode.sv
// Extracts the signed count field and splits it into a direction and a magnitude.
module shf_count_decode #(
  parameter int AMT_W = 16,
  parameter int CNT_W = 6
) (
  input  logic [AMT_W-1:0] amt_hw,
  output logic             go_right,
  output logic [CNT_W-1:0] mag
);
  logic [CNT_W-1:0] field;
  logic             unused_hi;

  assign field     = amt_hw[CNT_W-1:0];
  assign unused_hi = ^amt_hw[AMT_W-1:CNT_W];
  assign go_right  = field[CNT_W-1];
  // The magnitude of the most negative count (100000b) is 32, which still fits unsigned.
  assign mag       = go_right ? (~field + 1'b1) : field;
endmodule

// File: rtl/shf_barrel.sv
// Logarithmic shifter: one stage per magnitude bit, plus a full-width fill stage.
module shf_barrel #(
  parameter int DATA_W = 32,
  parameter int LOG_W  = 5
) (
  input  logic [DATA_W-1:0] din,
  input  logic              go_right,
  input  logic              fill_bit,
  input  logic [LOG_W:0]    mag,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stg [LOG_W+1];

  assign stg[0] = din;

  for (genvar i = 0; i < LOG_W; i++) begin : g_stage
    localparam int SH = 1 << i;
    logic [DATA_W-1:0] shl;
    logic [DATA_W-1:0] shr;
    assign shl = {stg[i][DATA_W-SH-1:0], {SH{1'b0}}};
    assign shr = {{SH{fill_bit}}, stg[i][DATA_W-1:SH]};
    assign stg[i+1] = !mag[i] ? stg[i] : (go_right ? shr : shl);
  end

  // Top magnitude bit is set only for a full-width right shift.
  always_comb begin
    if (mag[LOG_W]) dout = go_right ? {DATA_W{fill_bit}} : '0;
    else            dout = stg[LOG_W];
  end
endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   res,
  output shf_pkg::shf_flags_t flags
);
  always_comb begin
    flags.zero  = (res == '0);
    flags.neg   = res[DATA_W-1];
    flags.carry = 1'b0;
    flags.ovf0  = 1'b0;
    flags.ovf1  = 1'b0;
  end
endmodule

// File: rtl/shf_signed_shift.sv
module shf_signed_shift #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 16
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [AMT_W-1:0]  amt_hw,
  input  logic              mode_arith,
  output logic [DATA_W-1:0] res,
  output logic              flg_zero,
  output logic              flg_neg,
  output logic              flg_carry,
  output logic              flg_ovf0,
  output logic              flg_ovf1
);
  import shf_pkg::*;

  localparam int LOG_W = $clog2(DATA_W);
  localparam int CNT_W = LOG_W + 1;

  logic             go_right;
  logic [CNT_W-1:0] mag;
  logic             fill_bit;
  shf_mode_e        mode;
  shf_flags_t       flags;

  assign mode     = shf_mode_e'(mode_arith);
  assign fill_bit = (mode == SHF_ARITH) & op_a[DATA_W-1];

  shf_count_decode #(.AMT_W(AMT_W), .CNT_W(CNT_W)) u_dec (
    .amt_hw  (amt_hw),
    .go_right(go_right),
    .mag     (mag)
  );

  shf_barrel #(.DATA_W(DATA_W), .LOG_W(LOG_W)) u_bar (
    .din     (op_a),
    .go_right(go_right),
    .fill_bit(fill_bit),
    .mag     (mag),
    .dout    (res)
  );

  shf_flags #(.DATA_W(DATA_W)) u_flg (
    .res  (res),
    .flags(flags)
  );

  assign flg_zero  = flags.zero;
  assign flg_neg   = flags.neg;
  assign flg_carry = flags.carry;
  assign flg_ovf0  = flags.ovf0;
  assign flg_ovf1  = flags.ovf1;
endmodule

// File: rtl/shf_signed_shift_chk.sv
module shf_signed_shift_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 16
) (
  input logic [DATA_W-1:0] op_a,
  input logic [AMT_W-1:0]  amt_hw,
  input logic              mode_arith,
  input logic [DATA_W-1:0] res,
  input logic              flg_zero
);
  localparam int CNT_W = $clog2(DATA_W) + 1;

  logic [CNT_W-1:0]  cnt_f;
  logic              unused_hi;
  logic [DATA_W-1:0] low_mask;

  assign cnt_f     = amt_hw[CNT_W-1:0];
  assign unused_hi = ^amt_hw[AMT_W-1:CNT_W];

  always_comb begin
    low_mask = (DATA_W'(1) << cnt_f) - DATA_W'(1);
    if (cnt_f == '0)
      assert_zero_count_pass_R6: assert (res == op_a) else $error("R6 pass-through broken");
    if (!cnt_f[CNT_W-1] && cnt_f != '0)
      assert_left_zero_fill_R2: assert ((res & low_mask) == '0) else $error("R2 low fill not zero");
    if (cnt_f[CNT_W-1] && !mode_arith)
      assert_logic_top_clear_R4: assert (!res[DATA_W-1]) else $error("R4 logical fill not zero");
    if (cnt_f[CNT_W-1] && mode_arith)
      assert_arith_keeps_sign_R3: assert (res[DATA_W-1] == op_a[DATA_W-1]) else $error("R3 sign lost");
    if (op_a == '0)
      assert_zero_in_zero_flag_R7: assert (flg_zero) else $error("R7 zero flag missing");
  end
endmodule

bind shf_signed_shift shf_signed_shift_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .op_a      (op_a),
  .amt_hw    (amt_hw),
  .mode_arith(mode_arith),
  .res       (res),
  .flg_zero  (flg_zero)
);

// File: tb/tb_shf_signed_shift.sv
`timescale 1ns/1ps
module tb_shf_signed_shift;
  logic        clk = 1'b0;
  logic [31:0] op_a = '0;
  logic [15:0] amt_hw = '0;
  logic        mode_arith = 1'b0;
  logic [31:0] res;
  logic        flg_zero, flg_neg, flg_carry, flg_ovf0, flg_ovf1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  shf_signed_shift dut (
    .op_a(op_a), .amt_hw(amt_hw), .mode_arith(mode_arith), .res(res),
    .flg_zero(flg_zero), .flg_neg(flg_neg), .flg_carry(flg_carry),
    .flg_ovf0(flg_ovf0), .flg_ovf1(flg_ovf1)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [5:0] f, input logic ar);
    int c;
    int m;
    c = (f >= 6'd32) ? int'(f) - 64 : int'(f);
    if (c >= 0) return a << c;
    m = -c;
    if (ar) return (m >= 32) ? {32{a[31]}} : 32'($signed(a) >>> m);
    return (m >= 32) ? 32'd0 : (a >> m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%h amt=%h ar=%0b actual=%h expected=%h", tag, op_a, amt_hw, mode_arith, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [15:0] amt, input logic ar);
    @(negedge clk);
    op_a = a; amt_hw = amt; mode_arith = ar;
    #1;
  endtask

  task automatic full_check(input string tag);
    logic [31:0] e;
    e = model(op_a, amt_hw[5:0], mode_arith);
    chk(tag, res, e);
    chk("R7 zero flag", {31'd0, flg_zero}, {31'd0, e == 32'd0});
    chk("R8 neg flag", {31'd0, flg_neg}, {31'd0, e[31]});
    chk("R9 carry/ovf", {29'd0, flg_carry, flg_ovf0, flg_ovf1}, 32'd0);
  endtask

  initial begin
    logic [31:0] ops [6];
    logic [31:0] r_a;
    ops[0] = 32'h80000001; ops[1] = 32'h00000000; ops[2] = 32'hFFFFFFFF;
    ops[3] = 32'h12345678; ops[4] = 32'h00000100; ops[5] = 32'h7FFFFFFE;

    // idle state: all-zero inputs
    apply(32'd0, 16'd0, 1'b0);
    chk("R6 idle result", res, 32'd0);
    chk("R7 idle zero flag", {31'd0, flg_zero}, 32'd1);

    // document-style corner vectors
    apply(32'h80000001, 16'd31, 1'b1);   chk("R2 left 31", res, 32'h80000000);
    apply(32'h80000001, 16'd1, 1'b0);    chk("R2 left 1", res, 32'h00000002);
    apply(32'h80000001, 16'hFFFF, 1'b1); chk("R3 arith right 1", res, 32'hC0000000);
    apply(32'h80000001, 16'd32, 1'b1);   chk("R5 arith -32", res, 32'hFFFFFFFF);
    apply(32'h80000001, 16'd32, 1'b0);   chk("R5 logical -32", res, 32'h00000000);
    chk("R7 logical -32 zero", {31'd0, flg_zero}, 32'd1);
    apply(32'h80000001, 16'hFFE1, 1'b0); chk("R4 logical right 31", res, 32'h00000001);
    apply(32'h80000001, 16'd40, 1'b1);   chk("R1 40 arith", res, 32'hFFFFFF80);
    apply(32'h80000001, 16'd40, 1'b0);   chk("R1 40 logical", res, 32'h00000080);
    apply(32'h00000001, 16'd63, 1'b1);   chk("R1 63 as -1", res, 32'h00000000);
    apply(32'h00000100, 16'd255, 1'b1);  chk("R1 255 as -1", res, 32'h00000080);

    // upper amount bits have no effect
    apply(32'h12345678, 16'h0005, 1'b1); r_a = res;
    apply(32'h12345678, 16'hFFC5, 1'b1); chk("R1 upper bits ignored", res, r_a);

    // sweep: every count field, both modes, several operands, rotating upper bits
    for (int md = 0; md < 2; md++)
      for (int k = 0; k < 6; k++)
        for (int f = 0; f < 64; f++) begin
          logic [9:0] hi;
          logic [5:0] fld;
          string tag;
          hi  = 10'((f * 37 + k * 11 + md * 301) & 10'h3FF);
          fld = 6'(f);
          apply(ops[k], {hi, fld}, md[0]);
          if (f == 0)       tag = "R6 pass-through";
          else if (f < 32)  tag = "R2 left shift";
          else if (f == 32) tag = "R5 full right";
          else if (md == 1) tag = "R3 arith right";
          else              tag = "R4 logical right";
          full_check(tag);
          if (f == 0) chk("R6 equals operand", res, ops[k]);
        end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule